// File: doc/BRIEF.md
# Keyed Write-Unlock Sequencer

This block guards the start of a nonvolatile data-memory write. It sits on a small register bus and sees one access per instruction cycle; an instruction-cycle strobe marks which clocks are instruction cycles. A write can only start after software writes two key bytes to a key register and then sets a start bit in a control register. Each of those three accesses must arrive on an exact instruction-cycle spacing, and a software-owned enable bit must already be set. Only then does the block send a single-clock start pulse to the memory controller.

The memory controller is modelled as a busy counter. The start bit reads back as 1 while the counter runs. When it expires, a done flag is set. After any attempt, whether it succeeded or was refused, the block locks again, so every byte needs its own full unlock sequence. Any deviation blocks the write without any error indication.

Top module: `nvw_write_guard`

## Requirements
- R1: With the enable bit (control bit 0, address 0) already set, the access sequence is: 0x55 written to the key register (address 1), 0xAA written to the key register exactly SPACING strobes later, and the control register written with bit 1 set exactly SPACING strobes after that. This sequence produces exactly one single-clock `wr_go` pulse, on the clock after the strobe that carries the start write.
- R2: If the 0xAA write or the start write lands on any strobe other than the one required, no `wr_go` pulse is produced.
- R3: If the enable bit is 0 before the strobe carrying the start write, the write is refused. This holds even when that same access sets the enable bit.
- R4: The enable bit changes only when the control register is written; the hardware never clears it.
- R5: A key write whose value is not the expected next key byte, or a key or start write on a strobe before the deadline, returns the sequencer to the locked state.
- R6: After every start attempt, whether it succeeds or fails, the sequencer is locked. A later start write without a new key sequence has no effect.
- R7: The key register always reads back as 0x00.
- R8: Control bit 1 reads 1 for exactly BUSY_CYCLES clocks after `wr_go`, then clears by itself. When it clears, the done flag (control bit 2) is set. Writing 0 to bit 2 clears the done flag, and writing 1 to it has no effect.
- R9: Setting the start bit without a valid unlock, or while a write is busy, produces no pulse and does not restart the busy period.
- R10: While `rst_n` is low at a clock edge, the sequencer locks, and the enable, busy and done bits return to 0.
- R11: Clocks without `cyc_stb` do not count toward the spacing, and bus accesses on them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_stb | input | 1 | Instruction-cycle strobe; qualifies bus accesses and counts spacing |
| bus_we | input | 1 | Write enable for the current access |
| bus_addr | input | AW | Register address: 0 control, 1 key |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` (combinational) |
| wr_go | output | 1 | Single-clock start pulse to the memory controller |
| wr_busy | output | 1 | Write in progress |
| wr_done | output | 1 | Done flag |

## Verification
On every clock, the assertions check the following properties of each `wr_go` pulse: it is a single clock long, it comes only from the final unlock state, it requires the enable bit as it stood before the start write, and it never occurs while a write is busy. They also check that the enable bit stays put without a control write, that the done flag is set when busy falls, and that the key register reads zero. Other behaviours depend on a sequence of accesses, and only the bench's scenarios can show them. These are the exact strobe spacing, the lock after a wrong key byte, the need to repeat the key for each byte, the refusal when enable was set too late, and strobe counting that skips clocks without a strobe.

// File: rtl/nvw_pkg.sv
// Package: shared state encoding and control-register bit positions for
// the keyed write-unlock sequencer. Assumes an 8-bit or wider data bus.
package nvw_pkg;

    typedef enum logic [1:0] {
        SEQ_LOCKED = 2'd0,
        SEQ_GOT1   = 2'd1,
        SEQ_GOT2   = 2'd2
    } seq_state_e;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_START_BIT = 1;
    localparam int CTRL_DONE_BIT  = 2;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_KEY  = 1;

endpackage

// File: rtl/nvw_unlock_seq.sv
// Unlock sequencer: follows the key bytes and the start command, counting
// instruction-cycle strobes between the steps. start_ok is high on the
// strobe that carries a correctly timed start write. Assumes key_wr and
// ctrl_wr are already qualified by stb. SPACING must be at least 1.
module nvw_unlock_seq
    import nvw_pkg::*;
#(
    parameter int          DW        = 8,
    parameter int          SPACING   = 2,
    parameter logic [DW-1:0] KEY_FIRST  = 8'h55,
    parameter logic [DW-1:0] KEY_SECOND = 8'hAA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic          key_wr,
    input  logic [DW-1:0] key_data,
    input  logic          ctrl_wr,
    input  logic          start_set,
    output logic          start_ok,
    output seq_state_e    state_o
);
    localparam int CW = $clog2(SPACING + 1);
    localparam logic [CW-1:0] DEADLINE = CW'(SPACING);

    seq_state_e    state_q;
    logic [CW-1:0] gap_q;
    logic          deadline;
    logic          early_touch;

    // Decode whether this strobe is the required step slot, or an early access.
    always_comb begin
        deadline    = (gap_q == DEADLINE);
        early_touch = key_wr || (ctrl_wr && start_set);
        start_ok    = stb && (state_q == SEQ_GOT2) && deadline && ctrl_wr && start_set;
    end

    // Advance the sequencer one strobe at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_LOCKED;
            gap_q   <= '0;
        end else if (stb) begin
            case (state_q)
                SEQ_LOCKED: begin
                    if (key_wr && key_data == KEY_FIRST) begin
                        state_q <= SEQ_GOT1;
                        gap_q   <= CW'(1);
                    end
                end
                SEQ_GOT1: begin
                    if (deadline) begin
                        if (key_wr && key_data == KEY_SECOND) begin
                            state_q <= SEQ_GOT2;
                            gap_q   <= CW'(1);
                        end else begin
                            state_q <= SEQ_LOCKED;
                            gap_q   <= '0;
                        end
                    end else if (early_touch) begin
                        state_q <= SEQ_LOCKED;
                        gap_q   <= '0;
                    end else begin
                        gap_q <= gap_q + CW'(1);
                    end
                end
                SEQ_GOT2: begin
                    if (deadline || early_touch) begin
                        state_q <= SEQ_LOCKED;
                        gap_q   <= '0;
                    end else begin
                        gap_q <= gap_q + CW'(1);
                    end
                end
                default: begin
                    state_q <= SEQ_LOCKED;
                    gap_q   <= '0;
                end
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/nvw_busy_timer.sv
// Busy timer: stands in for the memory controller. A load starts a
// BUSY_CYCLES-clock busy period; finish is high on the last busy clock.
// Assumes load is never raised while busy (the top gates it).
module nvw_busy_timer #(
    parameter int BUSY_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy,
    output logic finish
);
    localparam int TW = $clog2(BUSY_CYCLES + 1);

    logic [TW-1:0] left_q;

    // Count down the remaining busy clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= TW'(BUSY_CYCLES);
        end else if (left_q != '0) begin
            left_q <= left_q - TW'(1);
        end
    end

    // Status taps from the counter.
    always_comb begin
        busy   = (left_q != '0);
        finish = (left_q == TW'(1));
    end

endmodule

// File: rtl/nvw_write_guard.sv
// Top: register decode, enable and done flags, and the start pulse.
// Address 0 is control (bit0 enable, bit1 start/busy, bit2 done) and
// address 1 is the write-only key. Assumes one bus access per strobe.
module nvw_write_guard
    import nvw_pkg::*;
#(
    parameter int AW          = 2,
    parameter int DW          = 8,
    parameter int SPACING     = 2,
    parameter int BUSY_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_stb,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          wr_go,
    output logic          wr_busy,
    output logic          wr_done
);
    logic       ctrl_wr;
    logic       key_wr;
    logic       start_ok;
    logic       launch;
    logic       finish;
    logic       en_q;
    logic       done_q;
    logic       go_q;
    seq_state_e seq_state;

    // Qualify bus writes by the instruction-cycle strobe.
    always_comb begin
        ctrl_wr = cyc_stb && bus_we && (bus_addr == AW'(ADDR_CTRL));
        key_wr  = cyc_stb && bus_we && (bus_addr == AW'(ADDR_KEY));
        launch  = start_ok && en_q && !wr_busy;
    end

    nvw_unlock_seq #(
        .DW      (DW),
        .SPACING (SPACING)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (cyc_stb),
        .key_wr    (key_wr),
        .key_data  (bus_wdata),
        .ctrl_wr   (ctrl_wr),
        .start_set (bus_wdata[CTRL_START_BIT]),
        .start_ok  (start_ok),
        .state_o   (seq_state)
    );

    nvw_busy_timer #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (launch),
        .busy   (wr_busy),
        .finish (finish)
    );

    // Enable bit: software-owned, written only by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (ctrl_wr) en_q <= bus_wdata[CTRL_EN_BIT];
    end

    // Done flag: set by the timer, cleared by writing 0; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     done_q <= 1'b0;
        else if (finish)                                done_q <= 1'b1;
        else if (ctrl_wr && !bus_wdata[CTRL_DONE_BIT])  done_q <= 1'b0;
    end

    // Register the one-shot start pulse toward the memory controller.
    always_ff @(posedge clk) begin
        if (!rst_n) go_q <= 1'b0;
        else        go_q <= launch;
    end

    // Read mux: the key register always reads zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(ADDR_CTRL)) begin
            bus_rdata[CTRL_EN_BIT]    = en_q;
            bus_rdata[CTRL_START_BIT] = wr_busy;
            bus_rdata[CTRL_DONE_BIT]  = done_q;
        end
    end

    assign wr_go   = go_q;
    assign wr_done = done_q;

endmodule

// File: rtl/nvw_write_guard_chk.sv
// Checker: cycle properties of the write guard, attached by bind.
// Assumes the top's internal names en_q, ctrl_wr and seq_state.
module nvw_write_guard_chk
    import nvw_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_go,
    input logic          wr_busy,
    input logic          wr_done,
    input logic          en_q,
    input logic          ctrl_wr,
    input seq_state_e    seq_state,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_rdata
);
    AST_GO_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) wr_go |=> !wr_go); // R1
    AST_GO_FROM_FINAL_STEP: assert property (@(posedge clk) disable iff (!rst_n) wr_go |-> $past(seq_state == SEQ_GOT2)); // R2
    AST_GO_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) wr_go |-> $past(en_q)); // R3
    AST_ENABLE_HELD: assert property (@(posedge clk) disable iff (!rst_n) $past(!ctrl_wr) |-> $stable(en_q)); // R4
    AST_GO_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) wr_go |-> wr_busy); // R8
    AST_DONE_AT_FINISH: assert property (@(posedge clk) disable iff (!rst_n) $fell(wr_busy) |-> wr_done); // R8
    AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (bus_addr == AW'(ADDR_KEY)) |-> (bus_rdata == '0)); // R7
    AST_NO_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) wr_go |-> $past(!wr_busy)); // R9
endmodule

bind nvw_write_guard nvw_write_guard_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_go     (wr_go),
    .wr_busy   (wr_busy),
    .wr_done   (wr_done),
    .en_q      (en_q),
    .ctrl_wr   (ctrl_wr),
    .seq_state (seq_state),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
);

// File: tb/sim_nvw_write_guard.sv
// Bench: behavioural reference model compared on every clock, plus
// scenario checks for each requirement.
module sim_nvw_write_guard;
    localparam int AW = 2;
    localparam int DW = 8;
    localparam int SPACING = 2;
    localparam int BUSY = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_stb = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          wr_go;
    logic          wr_busy;
    logic          wr_done;

    nvw_write_guard #(.AW(AW), .DW(DW), .SPACING(SPACING), .BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wr_go(wr_go), .wr_busy(wr_busy), .wr_done(wr_done)
    );

    always #4 clk = ~clk;

    int    checks = 0;
    int    fails = 0;
    bit    ended = 0;
    string tag = "R10";
    int    go_seen = 0;
    int    last_rd = 0;

    // reference model state
    int m_step = 0;   // 0 locked, 1 first key seen, 2 second key seen
    int m_gap = 0;
    int m_en = 0;
    int m_left = 0;
    int m_done = 0;
    int m_go = 0;

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int model_rd(input int a);
        if (a == 0) return m_en + 2 * (m_left != 0 ? 1 : 0) + 4 * m_done;
        return 0;
    endfunction

    task automatic model_edge(input int r, input int s, input int w, input int a, input int d);
        int kw, cw, start_bit, ok, go, n_step, n_gap, n_done, n_left, n_en;
        if (!r) begin
            m_step = 0; m_gap = 0; m_en = 0; m_left = 0; m_done = 0; m_go = 0;
            return;
        end
        kw = (s && w && a == 1) ? 1 : 0;
        cw = (s && w && a == 0) ? 1 : 0;
        start_bit = (d >> 1) & 1;
        ok = 0; n_step = m_step; n_gap = m_gap;
        if (s) begin
            if (m_step == 0) begin
                if (kw && d == 8'h55) begin n_step = 1; n_gap = 1; end
            end else if (m_gap == SPACING) begin
                if (m_step == 1 && kw && d == 8'hAA) begin n_step = 2; n_gap = 1; end
                else begin
                    if (m_step == 2 && cw && start_bit) ok = 1;
                    n_step = 0; n_gap = 0;
                end
            end else if (kw || (cw && start_bit)) begin
                n_step = 0; n_gap = 0;
            end else n_gap = m_gap + 1;
        end
        go = (ok && m_en && m_left == 0) ? 1 : 0;
        n_done = m_done;
        if (m_left == 1) n_done = 1;
        else if (cw && ((d >> 2) & 1) == 0) n_done = 0;
        n_left = go ? BUSY : (m_left > 0 ? m_left - 1 : 0);
        n_en = cw ? (d & 1) : m_en;
        m_step = n_step; m_gap = n_gap; m_done = n_done; m_left = n_left; m_en = n_en; m_go = go;
    endtask

    // one clock: compare registered outputs, drive, compare read data, clock the model
    task automatic bus(input int s, input int w, input int a, input int d);
        @(negedge clk);
        check(tag, int'(wr_go), m_go, "wr_go");
        check(tag, int'(wr_busy), (m_left != 0) ? 1 : 0, "wr_busy");
        check(tag, int'(wr_done), m_done, "wr_done");
        if (wr_go) go_seen++;
        cyc_stb = s[0]; bus_we = w[0]; bus_addr = AW'(a); bus_wdata = DW'(d);
        #1;
        last_rd = int'(bus_rdata);
        check(tag, last_rd, model_rd(a), "bus_rdata");
        @(posedge clk);
        model_edge(int'(rst_n), s, w, a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bus(1, 0, 0, 0);
    endtask

    task automatic unlock(input int g1, input int g2, input int ctrl);
        bus(1, 1, 1, 8'h55);
        idle(g1 - 1);
        bus(1, 1, 1, 8'hAA);
        idle(g2 - 1);
        bus(1, 1, 0, ctrl);
    endtask

    task automatic settle();
        for (int i = 0; i < BUSY + 3; i++) bus(0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int g0;
        // R10: reset state
        tag = "R10";
        rst_n = 1'b0;
        bus(1, 1, 0, 8'h07);
        bus(0, 0, 0, 0);
        rst_n = 1'b1;
        bus(1, 0, 0, 0);
        check("R10", last_rd, 0, "control after reset");

        // R1: full sequence with enable set
        tag = "R1";
        bus(1, 1, 0, 8'h01);
        g0 = go_seen;
        unlock(SPACING, SPACING, 8'h03);
        bus(0, 0, 0, 0);
        check("R1", go_seen - g0, 1, "pulses after valid unlock");
        // R8: busy reads 1 then done
        tag = "R8";
        bus(1, 0, 0, 0);
        check("R8", (last_rd >> 1) & 1, 1, "start bit while busy");
        settle();
        bus(1, 0, 0, 0);
        check("R8", last_rd, 8'h05, "done set, busy clear");
        bus(1, 1, 0, 8'h05);
        bus(1, 0, 0, 0);
        check("R8", last_rd, 8'h05, "writing 1 to done keeps it");
        bus(1, 1, 0, 8'h01);
        bus(1, 0, 0, 0);
        check("R8", last_rd, 8'h01, "done cleared, enable kept");

        // R2: wrong spacing
        tag = "R2";
        g0 = go_seen;
        unlock(SPACING - 1, SPACING, 8'h03); settle();
        unlock(SPACING + 1, SPACING, 8'h03); settle();
        unlock(SPACING, SPACING - 1, 8'h03); settle();
        unlock(SPACING, SPACING + 1, 8'h03); settle();
        check("R2", go_seen - g0, 0, "pulses with wrong spacing");

        // R3: enable clear beforehand, set by the start write itself
        tag = "R3";
        bus(1, 1, 0, 8'h00);
        g0 = go_seen;
        unlock(SPACING, SPACING, 8'h03); settle();
        check("R3", go_seen - g0, 0, "pulses with enable late");
        // R4: enable kept by hardware
        tag = "R4";
        bus(1, 0, 0, 0);
        check("R4", last_rd & 1, 1, "enable after refused write");

        // R5: wrong key values
        tag = "R5";
        g0 = go_seen;
        bus(1, 1, 1, 8'h55); idle(SPACING - 1); bus(1, 1, 1, 8'h5A); idle(SPACING - 1); bus(1, 1, 0, 8'h03);
        bus(1, 1, 1, 8'hAA); idle(SPACING - 1); bus(1, 1, 1, 8'h55); idle(SPACING - 1); bus(1, 1, 0, 8'h03);
        bus(1, 1, 1, 8'h12); idle(SPACING - 1); bus(1, 1, 1, 8'hAA); idle(SPACING - 1); bus(1, 1, 0, 8'h03);
        settle();
        check("R5", go_seen - g0, 0, "pulses after wrong key");

        // R6: each byte needs its own unlock
        tag = "R6";
        g0 = go_seen;
        unlock(SPACING, SPACING, 8'h03); settle();
        bus(1, 1, 0, 8'h03); settle();
        check("R6", go_seen - g0, 1, "second start without key");

        // R7: key reads zero
        tag = "R7";
        bus(1, 1, 1, 8'h55);
        bus(1, 0, 1, 0);
        check("R7", last_rd, 0, "key readback");
        idle(4);

        // R9: start while busy
        tag = "R9";
        g0 = go_seen;
        unlock(SPACING, SPACING, 8'h03);
        idle(2);
        unlock(SPACING, SPACING, 8'h03);
        bus(1, 0, 0, 0);
        check("R9", (last_rd >> 1) & 1, 1, "busy during second attempt");
        settle();
        check("R9", go_seen - g0, 1, "pulses with start while busy");
        bus(1, 1, 0, 8'h03); settle();
        check("R9", go_seen - g0, 1, "start without unlock");

        // R11: clocks without strobe are not counted
        tag = "R11";
        g0 = go_seen;
        bus(1, 1, 1, 8'h55); bus(0, 1, 1, 8'h55); bus(1, 0, 0, 0); bus(0, 1, 0, 8'h03);
        bus(1, 1, 1, 8'hAA); bus(0, 0, 0, 0); bus(0, 1, 1, 8'h12); bus(1, 0, 0, 0);
        bus(1, 1, 0, 8'h03);
        bus(0, 0, 0, 0);
        check("R11", go_seen - g0, 1, "pulses with sparse strobes");
        settle();

        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule